// File: doc/BRIEF.md
# Request-Driven Clock Gating Controller

This block hands a set of system clocks to a set of peripheral modules. Every module has its own gated line for every clock. A line carries its clock only while that module asks for it. A module asks through one of two request classes. A conditional request can be masked by software. An unconditional request, such as a watchdog's, can never be masked.

Software controls the masking through a small register port. There is one mask register per module, with one bit per clock, and one register of global per-clock enables. The global enables act on conditional requests only. The block reports which clocks are running and whether any clock is requested at all. From that it answers a low-power entry request from the power controller. It refuses the entry while any qualified request is live, unless the entry is forced.

Each line is gated by a cell that samples its enable only while the source clock is low. A change in the enable therefore never cuts a high phase short and never starts a partial one.

Top module: `clkreq_gate_ctrl`

## Requirements
- R1: Gated line `m*N_CLK+c` is low whenever that line has no qualified request. A request is qualified when it is unconditional, or when it is conditional with mask bit c of module m set and global enable c set. A qualified line copies `sys_clk[c]`.
- R2: Module m's mask register is at address m+1, with bit c belonging to clock c, and it resets to all ones. A cleared bit masks module m's conditional request for clock c. A set bit unmasks it.
- R3: An unconditional request keeps its clock running no matter what the mask and global enable values are.
- R4: The global enable register is at address 0, with bit c belonging to clock c, and it resets to all ones. With bit c at 0, clock c is stopped for every conditional request.
- R5: A cleared global enable stays cleared through a complete low-power request and grant exchange. It is never set again without a write.
- R6: A register write changes `clk_run` in the cycle right after the write edge. It adds no extra pipeline delay.
- R7: `lpm_ack` rises one clock after `lpm_req` is sampled high while no qualified request is live, or while `lpm_force` is high.
- R8: `lpm_ack` stays low while `lpm_req` is high, any qualified request is live and `lpm_force` is low.
- R9: A gated line changes only while its source clock is low. An enable change during the high phase does not show until the next high phase.
- R10: `clk_run[c]` is the OR of the qualified requests for clock c over all modules. `clk_requested` is the OR of `clk_run`.
- R11: A write to an address above N_MOD changes no register, and a read from such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and handshake clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address (0 = global enables, m+1 = module m mask) |
| wr_data | input | N_CLK | Write data, one bit per clock |
| rd_addr | input | AW | Read address |
| rd_data | output | N_CLK | Read data for rd_addr |
| sys_clk | input | N_CLK | Ungated system clocks |
| req_cond | input | N_MOD*N_CLK | Conditional requests, line m*N_CLK+c |
| req_uncond | input | N_MOD*N_CLK | Unconditional requests, line m*N_CLK+c |
| gclk | output | N_MOD*N_CLK | Gated clock lines |
| clk_run | output | N_CLK | Clock c has at least one qualified request |
| clk_requested | output | 1 | Any clock is requested |
| lpm_req | input | 1 | Low-power entry request |
| lpm_force | input | 1 | Force low-power entry despite live requests |
| lpm_ack | output | 1 | Low-power entry granted |

## Verification
The bench builds the block with N_MOD=3 and N_CLK=2, which gives six lines and a 3-bit address. At that size it can run every global-enable value and every mask pattern against every conditional-request pattern. For each of these it uses three unconditional patterns, and it computes the expected lines and status from the qualification formula. The spare addresses 4 to 7 give the bench room to test out-of-range writes and reads. The bench drives the two system clocks by hand, which puts enable changes inside a high phase within reach of the test.

// File: rtl/cg_pkg.sv
// Package shared by the clock gating controller.
// Holds the register map constant and the line indexing helper.
// Assumes line index = module * clock count + clock.
package cg_pkg;
    localparam int unsigned ADDR_GLOBAL = 0;

    // Line index of module m, clock c in an nclk-wide layout.
    function automatic int unsigned line_of(input int unsigned m,
                                            input int unsigned c,
                                            input int unsigned nclk);
        return m * nclk + c;
    endfunction
endpackage

// File: rtl/cg_regfile.sv
// Control registers: global per-clock enables at address 0 and one
// per-module mask register at address m+1. All bits reset to 1.
// Assumes a single write port and a combinational read port.
module cg_regfile #(
    parameter int N_MOD = 3,
    parameter int N_CLK = 2,
    parameter int AW    = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [N_CLK-1:0]       wr_data,
    input  logic [AW-1:0]          rd_addr,
    output logic [N_CLK-1:0]       rd_data,
    output logic [N_CLK-1:0]       glb_en,
    output logic [N_MOD*N_CLK-1:0] mod_en
);
    import cg_pkg::*;

    logic [N_CLK-1:0]       glb_q;
    logic [N_MOD*N_CLK-1:0] mod_q;

    // Register update on writes; out-of-range addresses match nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_q <= '1;
            mod_q <= '1;
        end else if (wr_en) begin
            if (wr_addr == AW'(ADDR_GLOBAL))
                glb_q <= wr_data;
            for (int m = 0; m < N_MOD; m++) begin
                if (wr_addr == AW'(m + 1))
                    mod_q[m*N_CLK +: N_CLK] <= wr_data;
            end
        end
    end

    // Read mux; unmapped addresses return zero.
    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(ADDR_GLOBAL))
            rd_data = glb_q;
        for (int m = 0; m < N_MOD; m++) begin
            if (rd_addr == AW'(m + 1))
                rd_data = mod_q[m*N_CLK +: N_CLK];
        end
    end

    assign glb_en = glb_q;
    assign mod_en = mod_q;
endmodule

// File: rtl/cg_qualify.sv
// Request qualification: unconditional requests always pass; conditional
// ones need both the module mask bit and the clock's global enable.
// Purely combinational so register changes act without extra delay.
module cg_qualify #(
    parameter int N_MOD = 3,
    parameter int N_CLK = 2
) (
    input  logic [N_MOD*N_CLK-1:0] req_cond,
    input  logic [N_MOD*N_CLK-1:0] req_uncond,
    input  logic [N_MOD*N_CLK-1:0] mod_en,
    input  logic [N_CLK-1:0]       glb_en,
    output logic [N_MOD*N_CLK-1:0] line_en,
    output logic [N_CLK-1:0]       clk_run
);
    import cg_pkg::*;

    // One qualifier per line.
    for (genvar m = 0; m < N_MOD; m++) begin : g_mod
        for (genvar c = 0; c < N_CLK; c++) begin : g_clk
            localparam int unsigned L = line_of(m, c, N_CLK);
            assign line_en[L] = req_uncond[L] |
                                (req_cond[L] & mod_en[L] & glb_en[c]);
        end
    end

    // Per-clock OR over all modules.
    always_comb begin
        clk_run = '0;
        for (int m = 0; m < N_MOD; m++)
            clk_run = clk_run | line_en[m*N_CLK +: N_CLK];
    end
endmodule

// File: rtl/cg_icg.sv
// Latch-based clock gate. The enable is captured while clk_in is low
// and held through the high phase, so no runt pulse can appear.
// Assumes en settles before clk_in rises.
module cg_icg (
    input  logic clk_in,
    input  logic en,
    output logic gclk
);
    logic en_lat;

    // Transparent while the source clock is low.
    always_latch begin
        if (!clk_in)
            en_lat = en;
    end

    assign gclk = clk_in & en_lat;
endmodule

// File: rtl/cg_lpm_hs.sv
// Low-power handshake: grants entry one clock after a request when
// nothing is requested or entry is forced; drops when the request drops.
// Assumes lpm_req is synchronous to clk.
module cg_lpm_hs (
    input  logic clk,
    input  logic rst_n,
    input  logic lpm_req,
    input  logic lpm_force,
    input  logic busy,
    output logic lpm_ack
);
    logic ack_q;

    // Registered grant decision.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ack_q <= 1'b0;
        else
            ack_q <= lpm_req & (lpm_force | ~busy);
    end

    assign lpm_ack = ack_q;
endmodule

// File: rtl/clkreq_gate_ctrl.sv
// Top of the request-driven clock gating controller. It ties the
// register file, the qualifier, one clock gate per line and the
// low-power handshake together. Line m*N_CLK+c carries sys_clk[c] to
// module m. Assumes the register port and handshake run on clk.
module clkreq_gate_ctrl #(
    parameter int N_MOD = 3,
    parameter int N_CLK = 2,
    localparam int N_LINE = N_MOD * N_CLK,
    localparam int AW     = $clog2(N_MOD + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [N_CLK-1:0]  wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [N_CLK-1:0]  rd_data,
    input  logic [N_CLK-1:0]  sys_clk,
    input  logic [N_LINE-1:0] req_cond,
    input  logic [N_LINE-1:0] req_uncond,
    output logic [N_LINE-1:0] gclk,
    output logic [N_CLK-1:0]  clk_run,
    output logic              clk_requested,
    input  logic              lpm_req,
    input  logic              lpm_force,
    output logic              lpm_ack
);
    import cg_pkg::*;

    logic [N_CLK-1:0]  glb_en;
    logic [N_LINE-1:0] mod_en;
    logic [N_LINE-1:0] line_en;

    cg_regfile #(.N_MOD(N_MOD), .N_CLK(N_CLK), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .glb_en  (glb_en),
        .mod_en  (mod_en)
    );

    cg_qualify #(.N_MOD(N_MOD), .N_CLK(N_CLK)) u_qual (
        .req_cond   (req_cond),
        .req_uncond (req_uncond),
        .mod_en     (mod_en),
        .glb_en     (glb_en),
        .line_en    (line_en),
        .clk_run    (clk_run)
    );

    // One glitch-free gate per module/clock line.
    for (genvar m = 0; m < N_MOD; m++) begin : g_gate_mod
        for (genvar c = 0; c < N_CLK; c++) begin : g_gate_clk
            localparam int unsigned L = line_of(m, c, N_CLK);
            cg_icg u_icg (
                .clk_in (sys_clk[c]),
                .en     (line_en[L]),
                .gclk   (gclk[L])
            );
        end
    end

    assign clk_requested = |clk_run;

    cg_lpm_hs u_lpm (
        .clk       (clk),
        .rst_n     (rst_n),
        .lpm_req   (lpm_req),
        .lpm_force (lpm_force),
        .busy      (clk_requested),
        .lpm_ack   (lpm_ack)
    );
endmodule

// File: rtl/clkreq_gate_ctrl_chk.sv
// Checker for the clock gating controller, attached by bind. It samples
// the ports and the global enables on the control clock.
module clkreq_gate_ctrl_chk #(
    parameter int N_MOD = 3,
    parameter int N_CLK = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_CLK-1:0]       sys_clk,
    input logic [N_MOD*N_CLK-1:0] req_cond,
    input logic [N_MOD*N_CLK-1:0] req_uncond,
    input logic [N_MOD*N_CLK-1:0] gclk,
    input logic [N_CLK-1:0]       glb_en,
    input logic [N_CLK-1:0]       clk_run,
    input logic                   clk_requested,
    input logic                   lpm_req,
    input logic                   lpm_force,
    input logic                   lpm_ack
);
    logic [N_CLK-1:0] col_any;
    logic [N_CLK-1:0] col_unc;

    // Per-clock OR of raw requests, any class and unconditional only.
    always_comb begin
        col_any = '0;
        col_unc = '0;
        for (int m = 0; m < N_MOD; m++) begin
            col_any = col_any | req_cond[m*N_CLK +: N_CLK] | req_uncond[m*N_CLK +: N_CLK];
            col_unc = col_unc | req_uncond[m*N_CLK +: N_CLK];
        end
    end

    for (genvar c = 0; c < N_CLK; c++) begin : g_c
        assert_run_needs_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
            clk_run[c] |-> col_any[c]);
        assert_global_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!glb_en[c] && !col_unc[c]) |-> !clk_run[c]);
        assert_status_or_R10: assert property (@(posedge clk) disable iff (!rst_n)
            clk_run[c] |-> clk_requested);
        for (genvar m = 0; m < N_MOD; m++) begin : g_m
            assert_uncond_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
                req_uncond[m*N_CLK+c] |-> clk_run[c]);
            assert_low_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !sys_clk[c] |-> !gclk[m*N_CLK+c]);
        end
    end

    assert_lpm_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lpm_req && (lpm_force || !clk_requested)) |=> lpm_ack);
    assert_lpm_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lpm_req && clk_requested && !lpm_force) |=> !lpm_ack);
endmodule

bind clkreq_gate_ctrl clkreq_gate_ctrl_chk #(.N_MOD(N_MOD), .N_CLK(N_CLK)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sys_clk       (sys_clk),
    .req_cond      (req_cond),
    .req_uncond    (req_uncond),
    .gclk          (gclk),
    .glb_en        (glb_en),
    .clk_run       (clk_run),
    .clk_requested (clk_requested),
    .lpm_req       (lpm_req),
    .lpm_force     (lpm_force),
    .lpm_ack       (lpm_ack)
);

// File: tb/clkreq_gate_ctrl_tb.sv
// Bench: 3 modules x 2 clocks, sweeping enables, masks and requests.
module clkreq_gate_ctrl_tb;
    localparam int NM = 3;
    localparam int NC = 2;
    localparam int NL = NM * NC;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [NC-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [NC-1:0] rd_data;
    logic [NC-1:0] sys_clk = '0;
    logic [NL-1:0] req_cond = '0;
    logic [NL-1:0] req_uncond = '0;
    logic [NL-1:0] gclk;
    logic [NC-1:0] clk_run;
    logic          clk_requested;
    logic          lpm_req = 1'b0;
    logic          lpm_force = 1'b0;
    logic          lpm_ack;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    clkreq_gate_ctrl #(.N_MOD(NM), .N_CLK(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .sys_clk(sys_clk), .req_cond(req_cond), .req_uncond(req_uncond),
        .gclk(gclk), .clk_run(clk_run), .clk_requested(clk_requested),
        .lpm_req(lpm_req), .lpm_force(lpm_force), .lpm_ack(lpm_ack)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [AW-1:0] a, input logic [NC-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [NL-1:0] exp_lines(input logic [NL-1:0] c, input logic [NL-1:0] u,
                                                input logic [NL-1:0] me, input logic [NC-1:0] ge);
        logic [NL-1:0] q;
        for (int l = 0; l < NL; l++)
            q[l] = u[l] | (c[l] & me[l] & ge[l % NC]);
        return q;
    endfunction

    function automatic logic [NC-1:0] exp_run(input logic [NL-1:0] q);
        logic [NC-1:0] r = '0;
        for (int m = 0; m < NM; m++)
            r = r | q[m*NC +: NC];
        return r;
    endfunction

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [NL-1:0] q;
        logic [NL-1:0] u;
        repeat (3) @(negedge clk);
        // Reset state (R2, R4, R7)
        rd_addr = 3'd0; #1;
        check("R4 global reset value", rd_data, 2'b11);
        for (int m = 1; m <= NM; m++) begin
            rd_addr = AW'(m); #1;
            check("R2 mask reset value", rd_data, 2'b11);
        end
        check("R7 ack low in reset", lpm_ack, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Full sweep: global enables, masks, conditional requests (R1-R4, R9, R10)
        for (int ge = 0; ge < 4; ge++) begin
            for (int me = 0; me < 64; me++) begin
                write_reg(3'd0, NC'(ge));
                for (int m = 0; m < NM; m++)
                    write_reg(AW'(m + 1), NC'(me >> (2 * m)));
                for (int cv = 0; cv < 64; cv++) begin
                    for (int k = 0; k < 3; k++) begin
                        u = (k == 0) ? 6'h00 : (k == 1) ? 6'h21 : (NL'(cv) ^ 6'h15);
                        req_cond = NL'(cv); req_uncond = u; sys_clk = '0;
                        #1;
                        q = exp_lines(NL'(cv), u, NL'(me), NC'(ge));
                        check("R10 clk_run", clk_run, exp_run(q));
                        check("R10 clk_requested", clk_requested, |exp_run(q));
                        check("R9 lines low in low phase", gclk, '0);
                        sys_clk = 2'b11; #1;
                        check("R1 R2 R3 R4 gated lines", gclk, q);
                        req_cond = ~NL'(cv); req_uncond = ~u; #1;
                        check("R9 lines hold in high phase", gclk, q);
                        sys_clk = '0; #1;
                    end
                end
            end
        end
        req_cond = '0; req_uncond = '0;
        write_reg(3'd0, 2'b11);
        for (int m = 0; m < NM; m++) write_reg(AW'(m + 1), 2'b11);

        // Immediate effect of a mask write (R6)
        write_reg(3'd1, 2'b00);
        @(negedge clk);
        req_cond = 6'b000001; #1;
        check("R2 masked request", clk_run, 2'b00);
        write_reg(3'd1, 2'b01);
        check("R6 unmask seen next cycle", clk_run, 2'b01);
        write_reg(3'd1, 2'b00);
        check("R6 mask seen next cycle", clk_run, 2'b00);
        write_reg(3'd1, 2'b11);

        // Low-power handshake (R7, R8)
        @(negedge clk);
        lpm_req = 1'b1;
        @(negedge clk);
        check("R8 refused while requested", lpm_ack, 1'b0);
        lpm_force = 1'b1;
        @(negedge clk);
        check("R7 forced grant", lpm_ack, 1'b1);
        lpm_force = 1'b0; req_cond = '0;
        @(negedge clk);
        check("R7 grant when idle", lpm_ack, 1'b1);
        req_uncond = 6'b100000;
        @(negedge clk);
        check("R8 unconditional blocks entry", lpm_ack, 1'b0);
        lpm_req = 1'b0; req_uncond = '0;
        @(negedge clk);

        // Global enable survives a low-power exchange (R5)
        write_reg(3'd0, 2'b10);
        lpm_req = 1'b1;
        repeat (2) @(negedge clk);
        check("R5 entry granted", lpm_ack, 1'b1);
        lpm_req = 1'b0;
        repeat (2) @(negedge clk);
        rd_addr = 3'd0; #1;
        check("R5 global enable still cleared", rd_data, 2'b10);
        req_cond = 6'b000101; #1;
        check("R5 clock 0 still off", clk_run, 2'b00);
        req_cond = '0;

        // Out-of-range addresses (R11)
        for (int a = NM + 1; a < 8; a++) begin
            write_reg(AW'(a), 2'b00);
            rd_addr = AW'(a); #1;
            check("R11 unmapped read zero", rd_data, 2'b00);
        end
        rd_addr = 3'd0; #1;
        check("R11 global untouched", rd_data, 2'b10);
        for (int m = 1; m <= NM; m++) begin
            rd_addr = AW'(m); #1;
            check("R11 mask untouched", rd_data, 2'b11);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule